// File: doc/BRIEF.md
# Access Bank Operand Address Resolver

This block converts the 8-bit register operand of an instruction into a 12-bit data memory address. The operand is resolved either through the access bank, a fixed 256-location view made of the bottom of bank 0 plus the special function register area, or through the bank select register, which supplies the upper four address bits. An extended mode relocates the lowest 96 access locations to a movable window. The window starts at a 12-bit pointer value and spans that pointer plus 0 through 95.

Each accepted request produces a registered address and a 3-bit region code. Downstream memory and debug logic use the code to tell which mapping rule applied. The block only resolves addresses. Storage, instruction decode and the registers that supply the pointer and bank number are outside it.

Top module: `opnd_addr_resolver`

## Requirements
- R1: With ext_en=1, use_bank=0 and opnd below 60h, addr equals ptr+opnd and region is 0 (window).
- R2: With ext_en=0, use_bank=0 and opnd below 60h, addr equals 000h+opnd and region is 1 (bank 0 low).
- R3: With use_bank=0 and opnd in 60h..7Fh, addr equals opnd with upper nibble 0 and region is 2 (bank 0 middle), whatever ext_en is.
- R4: With use_bank=0 and opnd in 80h..FFh, addr is {Fh, opnd} and region is 3 (special function registers), whatever ext_en is.
- R5: With use_bank=1, addr is {bank, opnd} and region is 4 (banked) in either mode, and ptr has no effect.
- R6: The window sum is taken modulo 4096, so ptr+opnd past FFFh wraps to low addresses.
- R7: A request with in_vld=1 appears on addr, region and out_vld=1 after exactly one rising edge. With in_vld=0, out_vld is 0 at the next edge and addr and region keep their values.
- R8: While rst_n is low, out_vld, addr and region are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request valid; captures the inputs below |
| opnd | input | 8 | Operand address field |
| use_bank | input | 1 | 1 = banked addressing, 0 = access bank |
| bank | input | 4 | Bank select register value |
| ptr | input | 12 | Window base pointer |
| ext_en | input | 1 | Extended (window) mode enable |
| out_vld | output | 1 | Result valid |
| addr | output | 12 | Resolved data memory address |
| region | output | 3 | Region code (0 window, 1 low, 2 middle, 3 SFR, 4 banked) |

## Verification
Two rules can apply in the same cycle: the window remap and the wraparound of its sum. They meet whenever the window is enabled with a pointer close to FFFh. The bench provokes this with pointer values FD0h and FFFh while sweeping every operand. It judges each result against ptr+opnd reduced modulo 4096 and against region code 0, so a missed carry or a wrong priority between the window and the bank 0 rule shows up as a mismatch. The same sweep runs with the mode bit and the access bit in both states, so the precedence of banked access over the window is checked on the same operands.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;
  typedef enum logic [2:0] {
    RG_WIN  = 3'd0,
    RG_LOW  = 3'd1,
    RG_MID  = 3'd2,
    RG_SFR  = 3'd3,
    RG_BANK = 3'd4
  } region_t;
endpackage

// File: rtl/win_sum.sv
module win_sum #(
  parameter int AW  = 12,
  parameter int OPW = 8
) (
  input  logic [AW-1:0]  base,
  input  logic [OPW-1:0] off,
  output logic [AW-1:0]  sum
);
  localparam int PADW = AW - OPW;

  // truncation to AW bits gives the modulo-2^AW wrap
  always_comb begin
    sum = base + {{PADW{1'b0}}, off};
  end
endmodule

// File: rtl/region_sel.sv
module region_sel
  import opnd_addr_pkg::*;
#(
  parameter int OPW       = 8,
  parameter int BANKW     = 4,
  parameter int WIN_SIZE  = 96,
  parameter int SFR_START = 128
) (
  input  logic [OPW-1:0]       opnd,
  input  logic                 use_bank,
  input  logic                 ext_en,
  input  logic [BANKW-1:0]     bank,
  input  logic [BANKW+OPW-1:0] win_addr,
  output logic [BANKW+OPW-1:0] nxt_addr,
  output region_t              nxt_region
);
  localparam logic [OPW-1:0] WIN_HI = OPW'(WIN_SIZE);
  localparam logic [OPW-1:0] SFR_LO = OPW'(SFR_START);

  // priority: banked, then SFR, then middle, then window/low
  always_comb begin
    nxt_addr   = {{BANKW{1'b0}}, opnd};
    nxt_region = RG_LOW;
    if (use_bank) begin
      nxt_addr   = {bank, opnd};
      nxt_region = RG_BANK;
    end else if (opnd >= SFR_LO) begin
      nxt_addr   = {{BANKW{1'b1}}, opnd};
      nxt_region = RG_SFR;
    end else if (opnd >= WIN_HI) begin
      nxt_addr   = {{BANKW{1'b0}}, opnd};
      nxt_region = RG_MID;
    end else if (ext_en) begin
      nxt_addr   = win_addr;
      nxt_region = RG_WIN;
    end
  end
endmodule

// File: rtl/res_reg.sv
module res_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/opnd_addr_resolver.sv
module opnd_addr_resolver
  import opnd_addr_pkg::*;
#(
  parameter int OPW       = 8,
  parameter int BANKW     = 4,
  parameter int WIN_SIZE  = 96,
  parameter int SFR_START = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [OPW-1:0]       opnd,
  input  logic                 use_bank,
  input  logic [BANKW-1:0]     bank,
  input  logic [BANKW+OPW-1:0] ptr,
  input  logic                 ext_en,
  output logic                 out_vld,
  output logic [BANKW+OPW-1:0] addr,
  output logic [2:0]           region
);
  localparam int AW = BANKW + OPW;
  localparam int RW = 3;

  logic [AW-1:0] win_addr;
  logic [AW-1:0] nxt_addr;
  region_t       nxt_region;
  logic          vld_nxt;

  win_sum #(.AW(AW), .OPW(OPW)) u_sum (
    .base (ptr),
    .off  (opnd),
    .sum  (win_addr)
  );

  region_sel #(
    .OPW(OPW), .BANKW(BANKW), .WIN_SIZE(WIN_SIZE), .SFR_START(SFR_START)
  ) u_sel (
    .opnd       (opnd),
    .use_bank   (use_bank),
    .ext_en     (ext_en),
    .bank       (bank),
    .win_addr   (win_addr),
    .nxt_addr   (nxt_addr),
    .nxt_region (nxt_region)
  );

  res_reg #(.W(AW)) u_areg (
    .clk (clk), .rst_n (rst_n), .en (in_vld), .d (nxt_addr), .q (addr)
  );

  res_reg #(.W(RW)) u_rreg (
    .clk (clk), .rst_n (rst_n), .en (in_vld), .d (RW'(nxt_region)), .q (region)
  );

  always_comb begin
    vld_nxt = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= vld_nxt;
  end

  // output timing
  assert_vld_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(addr) && $stable(region)));

  // banked access takes the bank number as the upper bits
  assert_banked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && use_bank) |=>
      (region == 3'd4 && addr == {$past(bank), $past(opnd)}));

  // region codes agree with the address range they report
  assert_sfr_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && region == 3'd3) |-> (addr[AW-1:OPW] == {BANKW{1'b1}}));
  assert_mid_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && region == 3'd2) |->
      (addr >= AW'(WIN_SIZE) && addr < AW'(SFR_START)));
  assert_low_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && region == 3'd1) |-> (addr < AW'(WIN_SIZE)));
  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (region <= 3'd4));
endmodule

// File: tb/sim_opnd_addr_resolver.sv
module sim_opnd_addr_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [7:0]  opnd;
  logic        use_bank;
  logic [3:0]  bank;
  logic [11:0] ptr;
  logic        ext_en;
  logic        out_vld;
  logic [11:0] addr;
  logic [2:0]  region;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  opnd_addr_resolver u0 (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .opnd (opnd),
    .use_bank (use_bank), .bank (bank), .ptr (ptr), .ext_en (ext_en),
    .out_vld (out_vld), .addr (addr), .region (region)
  );

  task automatic chk(string tag, logic v, logic [11:0] ea, logic [2:0] er, logic ev);
    total++;
    if (v !== ev || addr !== ea || region !== er) begin
      bad++;
      $display("FAIL %s: vld=%0b addr=%03h region=%0d expected vld=%0b addr=%03h region=%0d",
               tag, v, addr, region, ev, ea, er);
    end
  endtask

  logic [11:0] e_addr;
  logic [2:0]  e_reg;
  string       e_tag;

  task automatic expect_of(int op, bit ub, int bk, int p, bit ex);
    int s;
    if (ub) begin
      e_addr = 12'(bk * 256 + op); e_reg = 3'd4; e_tag = "R5";
    end else if (op >= 128) begin
      e_addr = 12'(15 * 256 + op); e_reg = 3'd3; e_tag = "R4";
    end else if (op >= 96) begin
      e_addr = 12'(op); e_reg = 3'd2; e_tag = "R3";
    end else if (ex) begin
      s = p + op;
      e_tag = (s > 4095) ? "R6" : "R1";
      e_addr = 12'(s % 4096); e_reg = 3'd0;
    end else begin
      e_addr = 12'(op); e_reg = 3'd1; e_tag = "R2";
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int ptrs[5] = '{12'h000, 12'h120, 12'h7FF, 12'hFD0, 12'hFFF};
    int banks[3] = '{0, 5, 15};
    logic [11:0] held_a;
    logic [2:0]  held_r;
    rst_n = 1'b0; in_vld = 1'b0; opnd = 8'h00; use_bank = 1'b0;
    bank = 4'h0; ptr = 12'h000; ext_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", out_vld, 12'h000, 3'd0, 1'b0);
    // drive inputs while held in reset: outputs must stay clear
    in_vld = 1'b1; opnd = 8'hA5; use_bank = 1'b1; bank = 4'h7;
    @(negedge clk);
    chk("R8", out_vld, 12'h000, 3'd0, 1'b0);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", out_vld, 12'h000, 3'd0, 1'b0);

    // exhaustive sweep; each request is checked one edge later
    for (int pi = 0; pi < 5; pi++)
      for (int bi = 0; bi < 3; bi++)
        for (int ub = 0; ub < 2; ub++)
          for (int ex = 0; ex < 2; ex++)
            for (int op = 0; op < 256; op++) begin
              in_vld = 1'b1; opnd = 8'(op); use_bank = ub[0];
              bank = 4'(banks[bi]); ptr = 12'(ptrs[pi]); ext_en = ex[0];
              expect_of(op, ub[0], banks[bi], ptrs[pi], ex[0]);
              @(negedge clk);
              chk(e_tag, out_vld, e_addr, e_reg, 1'b1);
            end

    // R7: idle cycle keeps the last result and drops valid
    held_a = addr; held_r = region;
    in_vld = 1'b0; opnd = 8'h10; use_bank = 1'b0; ext_en = 1'b1; ptr = 12'h300;
    @(negedge clk);
    chk("R7", out_vld, held_a, held_r, 1'b0);
    @(negedge clk);
    chk("R7", out_vld, held_a, held_r, 1'b0);
    // R7: new request after idle shows up one edge later
    in_vld = 1'b1;
    @(negedge clk);
    chk("R7", out_vld, 12'h310, 3'd0, 1'b1);
    in_vld = 1'b0;
    @(negedge clk);
    chk("R7", out_vld, 12'h310, 3'd0, 1'b0);

    // R8: reset in mid-run clears the outputs
    rst_n = 1'b0;
    #1;
    chk("R8", out_vld, 12'h000, 3'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule